// File: doc/BRIEF.md
# Splittable Signed/Unsigned Hard Multiplier Tile

This tile multiplies two operands in one of two shapes. In full mode the two 18-bit operands produce one 36-bit product. In split mode the same datapath acts as two independent 9x9 multipliers. Each produces an 18-bit product, and the two products share the 36-bit output word side by side. Two run-time controls decide whether the X operand and the Y operand are read as two's-complement or as unsigned numbers. A signed operand can be combined with an unsigned one.

An input register stage and an output register stage can each be kept or bypassed through parameters. The pipeline latency is therefore 0, 1 or 2 clocks. The enabled stages share one clock, one clock enable and one synchronous active-high clear. The input stage captures the operands together with the mode and sign controls, so a mode change travels with the data it applies to.

Top module: `split_mult`

## Requirements
- R1: In full mode (`split`=0) with both sign controls low, `p` equals the unsigned 36-bit product of `x` and `y`.
- R2: In full mode with both sign controls high, `p` equals the two's-complement product of `x` and `y`, truncated to 36 bits.
- R3: With exactly one sign control high, only the operand marked signed is sign-extended. The other operand is zero-extended, and `p` holds the 36-bit result.
- R4: In split mode (`split`=1), `p[17:0]` is the product of `x[8:0]` and `y[8:0]`, and `p[35:18]` is the product of `x[17:9]` and `y[17:9]`.
- R5: In split mode, `x_signed` applies to both 9-bit X halves and `y_signed` applies to both 9-bit Y halves.
- R6: A result appears on `p` IN_REG+OUT_REG rising clock edges after its operands are applied while `ce`=1. With the default parameters this is 2 edges.
- R7: `clr` high at a rising edge sets every enabled register to zero, so `p` reads 0 after that edge when OUT_REG=1.
- R8: While `ce` is low and `clr` is low, the enabled registers hold their contents and `p` does not change.
- R9: In split mode no carry or sign bit passes between the two lanes. An upper lane with a zero operand gives `p[35:18]`=0 whatever the lower lane holds.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock for both register stages |
| clr | input | 1 | Synchronous active-high clear of enabled registers |
| ce | input | 1 | Clock enable; low holds all enabled registers |
| split | input | 1 | 0 = one 18x18 multiply, 1 = two 9x9 multiplies |
| x_signed | input | 1 | 1 = X operand(s) are two's-complement |
| y_signed | input | 1 | 1 = Y operand(s) are two's-complement |
| x | input | 18 | X operand |
| y | input | 18 | Y operand |
| p | output | 36 | Product (full) or packed pair of lane products (split) |

## Verification
The hardest case to reach from the ports is a split-mode result in which the lower lane is at its most negative or largest value while the upper lane is zero or small. Any carry or sign spill between the lanes then shows up as a wrong upper half. The bench drives such operand pairs with both sign settings and compares each half separately. It also checks latency by holding a known result and then applying new operands. It samples `p` after one edge, when the old value must still be present, and again after the second edge, when the new value must appear.

// File: rtl/split_mult_pkg.sv
package split_mult_pkg;
  localparam int unsigned DEF_OP_W = 18;

  typedef enum logic {
    MODE_FULL  = 1'b0,
    MODE_SPLIT = 1'b1
  } mult_mode_e;
endpackage

// File: rtl/mult_pipe_reg.sv
module mult_pipe_reg #(
  parameter int unsigned W  = 8,
  parameter bit          EN = 1'b1
) (
  input  logic         clk,
  input  logic         clr,
  input  logic         ce,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);
  logic [W-1:0] r;

  always_ff @(posedge clk) begin
    if (clr)     r <= '0;
    else if (ce) r <= d;
  end

  assign q = EN ? r : d;

  generate
    if (EN) begin : g_chk
      // R7
      clr_zero_chk: assert property (@(posedge clk) clr |=> (r == '0));
      // R8
      hold_stable_chk: assert property (@(posedge clk) disable iff (clr)
        !ce |=> $stable(r));
      // R6
      load_one_cycle_chk: assert property (@(posedge clk) disable iff (clr)
        ce |=> (r == $past(d)));
    end
  endgenerate
endmodule

// File: rtl/mult_lane.sv
module mult_lane #(
  parameter int unsigned W = 9
) (
  input  logic [W-1:0]   a,
  input  logic [W-1:0]   b,
  input  logic           a_sgn,
  input  logic           b_sgn,
  output logic [2*W-1:0] prod
);
  logic [2*W-1:0] a_ext;
  logic [2*W-1:0] b_ext;

  // Only an operand marked signed gets its top bit replicated.
  assign a_ext = {{W{a_sgn & a[W-1]}}, a};
  assign b_ext = {{W{b_sgn & b[W-1]}}, b};
  // Low 2W bits of the product are the same for both readings once extended.
  assign prod  = a_ext * b_ext;
endmodule

// File: rtl/mult_core.sv
module mult_core #(
  parameter int unsigned OP_W = 18
) (
  input  logic [OP_W-1:0]   x,
  input  logic [OP_W-1:0]   y,
  input  logic              xs,
  input  logic              ys,
  input  logic              split,
  output logic [2*OP_W-1:0] prod
);
  localparam int unsigned HW = OP_W / 2;

  logic [2*OP_W-1:0] full_p;
  logic [2*HW-1:0]   half_p [2];

  mult_lane #(.W(OP_W)) u_full (
    .a(x), .b(y), .a_sgn(xs), .b_sgn(ys), .prod(full_p)
  );

  for (genvar h = 0; h < 2; h++) begin : g_half
    mult_lane #(.W(HW)) u_half (
      .a    (x[h*HW +: HW]),
      .b    (y[h*HW +: HW]),
      .a_sgn(xs),
      .b_sgn(ys),
      .prod (half_p[h])
    );
  end

  assign prod = split ? {half_p[1], half_p[0]} : full_p;
endmodule

// File: rtl/split_mult.sv
module split_mult #(
  parameter int unsigned OP_W    = split_mult_pkg::DEF_OP_W,
  parameter bit          IN_REG  = 1'b1,
  parameter bit          OUT_REG = 1'b1
) (
  input  logic              clk,
  input  logic              clr,
  input  logic              ce,
  input  logic              split,
  input  logic              x_signed,
  input  logic              y_signed,
  input  logic [OP_W-1:0]   x,
  input  logic [OP_W-1:0]   y,
  output logic [2*OP_W-1:0] p
);
  import split_mult_pkg::*;

  localparam int unsigned HW    = OP_W / 2;
  localparam int unsigned PW    = 2 * OP_W;
  localparam int unsigned BUN_W = 2 * OP_W + 3;

  logic [BUN_W-1:0] bun_d, bun_q;
  logic [OP_W-1:0]  cx, cy;
  logic             cxs, cys;
  mult_mode_e       cmode;
  logic [PW-1:0]    core_p;

  assign bun_d = {split, x_signed, y_signed, x, y};

  mult_pipe_reg #(.W(BUN_W), .EN(IN_REG)) u_in_stage (
    .clk(clk), .clr(clr), .ce(ce), .d(bun_d), .q(bun_q)
  );

  assign cmode = mult_mode_e'(bun_q[BUN_W-1]);
  assign cxs   = bun_q[BUN_W-2];
  assign cys   = bun_q[BUN_W-3];
  assign cx    = bun_q[2*OP_W-1:OP_W];
  assign cy    = bun_q[OP_W-1:0];

  mult_core #(.OP_W(OP_W)) u_core (
    .x(cx), .y(cy), .xs(cxs), .ys(cys),
    .split(cmode == MODE_SPLIT),
    .prod(core_p)
  );

  mult_pipe_reg #(.W(PW), .EN(OUT_REG)) u_out_stage (
    .clk(clk), .clr(clr), .ce(ce), .d(core_p), .q(p)
  );

  // R1
  full_unit_x_chk: assert property (@(posedge clk) disable iff (clr)
    (cmode == MODE_FULL && !cxs && !cys && cx == OP_W'(1))
      |-> (core_p == {{OP_W{1'b0}}, cy}));
  // R2
  full_neg_one_chk: assert property (@(posedge clk) disable iff (clr)
    (cmode == MODE_FULL && cxs && cys && cx == '1)
      |-> (core_p == PW'(-{{OP_W{cy[OP_W-1]}}, cy})));
  // R9
  lane_isolation_chk: assert property (@(posedge clk) disable iff (clr)
    (cmode == MODE_SPLIT && cx[OP_W-1:HW] == '0)
      |-> (core_p[PW-1:2*HW] == '0));
endmodule

// File: tb/split_mult_bench.sv
module split_mult_bench;
  localparam int CLK_PERIOD = 10;
  localparam int OW = 18;
  localparam int PWB = 36;

  logic           clk = 1'b0;
  logic           clr, ce, split, xs, ys;
  logic [OW-1:0]  x, y;
  logic [PWB-1:0] p;
  int n_chk = 0;
  int n_bad = 0;
  bit finished = 1'b0;

  split_mult u_split_mult (
    .clk(clk), .clr(clr), .ce(ce), .split(split),
    .x_signed(xs), .y_signed(ys), .x(x), .y(y), .p(p)
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  function automatic longint ext(input logic [OW-1:0] v, input int w, input bit s);
    longint r;
    r = longint'(v) & ((longint'(1) << w) - 1);
    if (s && v[w-1]) r = r - (longint'(1) << w);
    return r;
  endfunction

  function automatic logic [PWB-1:0] model(input logic [OW-1:0] a, input logic [OW-1:0] b,
                                           input bit as, input bit bs, input bit sp);
    longint lo, hi, f;
    if (!sp) begin
      f = ext(a, 18, as) * ext(b, 18, bs);
      return f[35:0];
    end
    lo = ext(a & 18'h1FF, 9, as) * ext(b & 18'h1FF, 9, bs);
    hi = ext(a >> 9, 9, as) * ext(b >> 9, 9, bs);
    return {hi[17:0], lo[17:0]};
  endfunction

  task automatic check(input string req, input logic [PWB-1:0] act, input logic [PWB-1:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic drive(input logic [OW-1:0] a, input logic [OW-1:0] b,
                       input bit as, input bit bs, input bit sp);
    @(negedge clk);
    x = a; y = b; xs = as; ys = bs; split = sp;
  endtask

  task automatic run_op(input string req, input logic [OW-1:0] a, input logic [OW-1:0] b,
                        input bit as, input bit bs, input bit sp);
    drive(a, b, as, bs, sp);
    @(posedge clk); @(posedge clk);
    @(negedge clk);
    check(req, p, model(a, b, as, bs, sp));
  endtask

  task automatic t_reset;
    check("R7 reset state", p, '0);
  endtask

  task automatic t_full_unsigned;
    run_op("R1 max*max", 18'h3FFFF, 18'h3FFFF, 0, 0, 0);
    run_op("R1 mixed bits", 18'h12345, 18'h0ABCD, 0, 0, 0);
  endtask

  task automatic t_full_signed;
    run_op("R2 -1*-1", 18'h3FFFF, 18'h3FFFF, 1, 1, 0);
    run_op("R2 min*min", 18'h20000, 18'h20000, 1, 1, 0);
    run_op("R2 min*max", 18'h20000, 18'h1FFFF, 1, 1, 0);
  endtask

  task automatic t_mixed;
    run_op("R3 x signed", 18'h3FFFF, 18'h3FFFF, 1, 0, 0);
    run_op("R3 y signed", 18'h00003, 18'h20000, 0, 1, 0);
  endtask

  task automatic t_split;
    run_op("R4 unsigned lanes", {9'd300, 9'd511}, {9'd7, 9'd511}, 0, 0, 1);
    run_op("R5 signed lanes", {9'h100, 9'h1FF}, {9'h0FF, 9'h100}, 1, 1, 1);
    run_op("R5 x signed lanes", {9'h1FF, 9'h1FE}, {9'h1FF, 9'h003}, 1, 0, 1);
  endtask

  task automatic t_isolation;
    run_op("R9 unsigned low full", {9'd0, 9'h1FF}, {9'h1AB, 9'h1FF}, 0, 0, 1);
    check("R9 upper zero", {18'd0, p[35:18]}, '0);
    run_op("R9 signed low min", {9'd0, 9'h100}, {9'h155, 9'h0FF}, 1, 1, 1);
    check("R9 upper zero signed", {18'd0, p[35:18]}, '0);
  endtask

  task automatic t_latency;
    run_op("R6 setup", 18'd5, 18'd7, 0, 0, 0);
    drive(18'd100, 18'd3, 0, 0, 0);
    @(posedge clk); @(negedge clk);
    check("R6 one edge old", p, 36'd35);
    @(posedge clk); @(negedge clk);
    check("R6 two edges new", p, 36'd300);
  endtask

  task automatic t_hold;
    @(negedge clk);
    ce = 1'b0; x = 18'd9; y = 18'd9;
    repeat (3) @(posedge clk);
    @(negedge clk);
    check("R8 hold", p, 36'd300);
    ce = 1'b1;
    repeat (2) @(posedge clk);
    @(negedge clk);
    check("R8 resume", p, 36'd81);
  endtask

  task automatic t_clear;
    @(negedge clk);
    clr = 1'b1;
    @(posedge clk); @(negedge clk);
    check("R7 clear", p, '0);
    clr = 1'b0;
    @(posedge clk); @(negedge clk);
    check("R7 input cleared", p, '0);
    @(posedge clk); @(negedge clk);
    check("R7 recover", p, 36'd81);
  endtask

  initial begin
    clr = 1'b1; ce = 1'b1; split = 1'b0; xs = 1'b0; ys = 1'b0; x = '0; y = '0;
    repeat (3) @(posedge clk);
    @(negedge clk);
    clr = 1'b0;
    t_reset();
    t_full_unsigned();
    t_full_signed();
    t_mixed();
    t_split();
    t_isolation();
    t_latency();
    t_hold();
    t_clear();
    if (!finished) begin
      finished = 1'b1;
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  end

  initial begin
    #(CLK_PERIOD * 100000);
    if (!finished) begin
      finished = 1'b1;
      n_chk++; n_bad++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  end
endmodule